// File: doc/BRIEF.md
# Dual DAC Register Interface

This block is the register front end for a pair of 12-bit digital-to-analog converter channels. It sits on an 8-bit special-function-register bus. Each channel has two data byte registers, and one shared control register serves both channels. Bus writes land in these held registers. The block then decides when each channel's live output code is refreshed from them. The converters, buffers and reference are outside the block. It drives them with a 12-bit code, a range select and a power enable per channel.

The block has two update disciplines. In immediate mode, writing a channel's low byte refreshes that channel at once, so software writes the high byte first. In deferred mode, data writes stay held. A later rising edge of the control register's sync bit then loads both channels on the same clock. A global width mode fills the code from the low byte alone. A per-channel clear forces the driven code to zero without destroying the held value.

Top module: `dual_dac_regs`

## Requirements
- R1: After reset, the control register reads 0x04 and all four data registers read 0x00. Both output codes are 0, and both power enables and both range selects are 0.
- R2: Address map: 0xF9 holds channel 0 low, 0xFA channel 0 high, 0xFB channel 1 low, 0xFC channel 1 high and 0xFD control. Reads return the register contents combinationally. Any other address reads 0x00, and writes to it change nothing.
- R3: Control bit positions are bit 7 width mode, bit 6 range of channel 1, bit 5 range of channel 0, bit 4 enable of channel 1, bit 3 enable of channel 0, bit 2 sync, bit 1 power of channel 1 and bit 0 power of channel 0.
- R4: In 12-bit mode (bit 7 = 0), a channel's transferred code is {high[3:0], low[7:0]}.
- R5: With sync = 1, a write to a channel's low byte refreshes that channel's code on the clock of the write. A write to the high byte alone leaves the code unchanged.
- R6: With sync = 0, data writes are stored and readable, but both output codes hold.
- R7: A control write that takes sync from 0 to 1 loads both channels on the same clock. The load uses the width mode and enable bits written in that same control write.
- R8: In 8-bit mode (bit 7 = 1), the transferred code is {low[7:0], 4'h0}. The high byte does not affect it.
- R9: An enable bit of 0 forces that channel's output code to 0. Setting it back to 1 restores the previously transferred code.
- R10: Each power output equals its control power bit (1 = on), and each range output equals its control range bit.
- R11: The upper nibble of each high byte register reads 0, whatever value is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr | input | 1 | Single-cycle write strobe |
| sfr_addr | input | 8 | Register address for writes and reads |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr |
| dac0_code | output | 12 | Channel 0 code to converter |
| dac1_code | output | 12 | Channel 1 code to converter |
| dac0_range | output | 1 | Channel 0 range select |
| dac1_range | output | 1 | Channel 1 range select |
| dac0_power | output | 1 | Channel 0 power enable |
| dac1_power | output | 1 | Channel 1 power enable |

## Verification
A single control write can raise sync and also change the width mode or release a channel's clear, so the simultaneous load and those other control effects land on one clock. The bench provokes this in two ways. It writes 0x9F while sync is low, which combines the rise with the switch to 8-bit mode. It writes 0x1F after 0x03, which combines the rise with both clears releasing. A correct result has both codes built from the held bytes under the newly written mode, and visible with no zero cycle and no stale value.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

    localparam int NUM_CH = 2;

    // Control register layout, most significant bit first.
    typedef struct packed {
        logic       narrow;   // 1: 8-bit width mode
        logic [1:0] rng;      // range select, index = channel
        logic [1:0] enable;   // 0 forces code to zero
        logic       sync;     // 1: immediate refresh on low byte write
        logic [1:0] pwr;      // 1 = powered
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{narrow: 1'b0, rng: 2'b00, enable: 2'b00,
                                     sync: 1'b1, pwr: 2'b00};

endpackage

// File: rtl/dual_dac_decode.sv
module dual_dac_decode
    import dual_dac_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  BASE   = 8'hF9
) (
    input  logic                           sfr_wr,
    input  logic [ADDR_W-1:0]              sfr_addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  lo_bytes,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  hi_bytes,
    input  logic [DATA_W-1:0]              ctrl_byte,
    output logic [NUM_CH-1:0]              wr_lo,
    output logic [NUM_CH-1:0]              wr_hi,
    output logic                           wr_ctrl,
    output logic [DATA_W-1:0]              rdata
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE) + ADDR_W'(2 * NUM_CH);

    logic [NUM_CH-1:0] hit_lo;
    logic [NUM_CH-1:0] hit_hi;
    logic              hit_ctrl;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE) + ADDR_W'(2 * c);
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE) + ADDR_W'(2 * c + 1);
        assign hit_lo[c] = (sfr_addr == LO_ADDR);
        assign hit_hi[c] = (sfr_addr == HI_ADDR);
    end

    assign hit_ctrl = (sfr_addr == CTRL_ADDR);
    assign wr_lo    = hit_lo & {NUM_CH{sfr_wr}};
    assign wr_hi    = hit_hi & {NUM_CH{sfr_wr}};
    assign wr_ctrl  = hit_ctrl & sfr_wr;

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_lo[c]) rdata = lo_bytes[c];
            if (hit_hi[c]) rdata = hi_bytes[c];
        end
        if (hit_ctrl) rdata = ctrl_byte;
    end

endmodule

// File: rtl/dual_dac_channel.sv
module dual_dac_channel #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              narrow,
    input  logic              load_now,
    input  logic              sync_rise,
    input  logic              enable,
    output logic [DATA_W-1:0] lo_byte,
    output logic [DATA_W-1:0] hi_byte,
    output logic [CODE_W-1:0] code
);

    localparam int HI_W  = CODE_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [HI_W-1:0]   hi;
        logic [CODE_W-1:0] live;
    } chan_t;

    chan_t             st_d, st_q;
    logic [CODE_W-1:0] staged;

    always_comb begin
        st_d = st_q;
        if (wr_lo) st_d.lo = wdata;
        if (wr_hi) st_d.hi = wdata[HI_W-1:0];
        staged = narrow ? {st_d.lo, {HI_W{1'b0}}} : {st_d.hi, st_d.lo};
        if ((wr_lo && load_now) || sync_rise) st_d.live = staged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_byte = st_q.lo;
    assign hi_byte = {{PAD_W{1'b0}}, st_q.hi};
    assign code    = enable ? st_q.live : '0;

endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
    import dual_dac_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter int         DATA_W = 8,
    parameter int         CODE_W = 12,
    parameter logic [7:0] BASE   = 8'hF9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_wr,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    output logic [CODE_W-1:0] dac0_code,
    output logic [CODE_W-1:0] dac1_code,
    output logic              dac0_range,
    output logic              dac1_range,
    output logic              dac0_power,
    output logic              dac1_power
);

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_CH-1:0]             wr_lo;
    logic [NUM_CH-1:0]             wr_hi;
    logic                          wr_ctrl;
    logic                          sync_rise;
    logic [NUM_CH-1:0][DATA_W-1:0] lo_bytes;
    logic [NUM_CH-1:0][DATA_W-1:0] hi_bytes;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;

    dual_dac_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BASE   (BASE)
    ) u_decode (
        .sfr_wr    (sfr_wr),
        .sfr_addr  (sfr_addr),
        .lo_bytes  (lo_bytes),
        .hi_bytes  (hi_bytes),
        .ctrl_byte (DATA_W'(ctrl_q)),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_ctrl   (wr_ctrl),
        .rdata     (sfr_rdata)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) ctrl_d = ctrl_t'(sfr_wdata[7:0]);
        sync_rise = wr_ctrl && ctrl_d.sync && !ctrl_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dual_dac_channel #(
            .DATA_W (DATA_W),
            .CODE_W (CODE_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (wr_lo[c]),
            .wr_hi     (wr_hi[c]),
            .wdata     (sfr_wdata),
            .narrow    (ctrl_d.narrow),
            .load_now  (ctrl_q.sync),
            .sync_rise (sync_rise),
            .enable    (ctrl_q.enable[c]),
            .lo_byte   (lo_bytes[c]),
            .hi_byte   (hi_bytes[c]),
            .code      (codes[c])
        );
    end

    assign dac0_code  = codes[0];
    assign dac1_code  = codes[1];
    assign dac0_range = ctrl_q.rng[0];
    assign dac1_range = ctrl_q.rng[1];
    assign dac0_power = ctrl_q.pwr[0];
    assign dac1_power = ctrl_q.pwr[1];

endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sfr_wr,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic [CODE_W-1:0] dac0_code,
    input logic [CODE_W-1:0] dac1_code,
    input logic              dac0_range,
    input logic              dac1_range,
    input logic              dac0_power,
    input logic              dac1_power
);

    localparam logic [ADDR_W-1:0] A_HI0  = ADDR_W'(8'hFA);
    localparam logic [ADDR_W-1:0] A_HI1  = ADDR_W'(8'hFC);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'hFD);

    // Shadow of the control register, rebuilt from bus traffic.
    logic [7:0] shadow_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          shadow_q <= 8'h04;
        else if (sfr_wr && sfr_addr == A_CTRL) shadow_q <= sfr_wdata[7:0];
    end

    logic ctrl_wr;
    assign ctrl_wr = sfr_wr && (sfr_addr == A_CTRL);

    // R6: deferred mode with no control write keeps both codes still.
    a_r6_hold_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadow_q[2] && !ctrl_wr) |=> ($stable(dac0_code) && $stable(dac1_code)));

    // R5: a high byte write alone never moves the code.
    a_r5_hi_no_move0: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == A_HI0) |=> $stable(dac0_code));
    a_r5_hi_no_move1: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == A_HI1) |=> $stable(dac1_code));

    // R9: a cleared channel drives zero.
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadow_q[3] |-> dac0_code == '0) and (!shadow_q[4] |-> dac1_code == '0));

    // R10: power and range follow the written control bits.
    a_r10_side_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (dac0_power == shadow_q[0]) && (dac1_power == shadow_q[1]) &&
        (dac0_range == shadow_q[5]) && (dac1_range == shadow_q[6]));

    // R11: high byte upper nibble reads zero.
    a_r11_hi_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == A_HI0 || sfr_addr == A_HI1) |-> (sfr_rdata[7:4] == 4'h0));

    // R8: in 8-bit mode the low nibble of each code is zero after a low byte refresh.
    a_r8_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q[7] && !ctrl_wr && shadow_q[2]) |=> (dac0_code[3:0] == 4'h0 || $stable(dac0_code)));

endmodule

bind dual_dac_regs dual_dac_regs_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
) u_chk (.*);

// File: tb/dual_dac_regs_test.sv
module dual_dac_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [11:0] dac0_code, dac1_code;
    logic        dac0_range, dac1_range, dac0_power, dac1_power;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string       req_q[$];
    logic [23:0] exp_q[$];

    always #2.5 clk = ~clk;

    dual_dac_regs uut (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .dac0_code(dac0_code), .dac1_code(dac1_code),
        .dac0_range(dac0_range), .dac1_range(dac1_range),
        .dac0_power(dac0_power), .dac1_power(dac1_power)
    );

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    // Driver side of the scoreboard: expected pair of codes.
    task automatic expect_codes(input string req, input logic [11:0] c0, input logic [11:0] c1);
        req_q.push_back(req);
        exp_q.push_back({c0, c1});
    endtask

    // Monitor: pops expectations after the next edge with no bus write.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (exp_q.size() > 0) begin
                automatic string       r = req_q.pop_front();
                automatic logic [23:0] e = exp_q.pop_front();
                checks++;
                if ({dac0_code, dac1_code} !== e) begin
                    errors++;
                    $display("FAIL %s codes actual %h/%h expected %h/%h",
                             r, dac0_code, dac1_code, e[23:12], e[11:0]);
                end
            end
        end
    end

    task automatic read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        sfr_addr = a;
        #1;
        checks++;
        if (sfr_rdata !== exp) begin
            errors++;
            $display("FAIL %s read %h actual %h expected %h", req, a, sfr_rdata, exp);
        end
    endtask

    task automatic side_check(input string req, input logic [3:0] exp);
        @(negedge clk);
        checks++;
        if ({dac1_range, dac0_range, dac1_power, dac0_power} !== exp) begin
            errors++;
            $display("FAIL %s range/power actual %b expected %b", req,
                     {dac1_range, dac0_range, dac1_power, dac0_power}, exp);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check("R1", 8'hFD, 8'h04);
        read_check("R1", 8'hF9, 8'h00);
        read_check("R1", 8'hFA, 8'h00);
        read_check("R1", 8'hFB, 8'h00);
        read_check("R1", 8'hFC, 8'h00);
        side_check("R1", 4'b0000);
        expect_codes("R1", 12'h000, 12'h000);

        // R3 R10: sync=1, enables on, power on, ranges low
        bus_write(8'hFD, 8'h1F);
        side_check("R10", 4'b0011);

        // R5 R11: high byte alone does not transfer, nibble reads zero
        bus_write(8'hFA, 8'hA5);
        expect_codes("R5", 12'h000, 12'h000);
        read_check("R11", 8'hFA, 8'h05);

        // R4 R5: low write transfers right-justified
        bus_write(8'hF9, 8'h3C);
        expect_codes("R4", 12'h53C, 12'h000);
        bus_write(8'hFC, 8'h0F);
        bus_write(8'hFB, 8'hFF);
        expect_codes("R4", 12'h53C, 12'hFFF);

        // R6: deferred mode holds outputs
        bus_write(8'hFD, 8'h1B);
        bus_write(8'hFA, 8'h01);
        bus_write(8'hF9, 8'h23);
        bus_write(8'hFB, 8'h00);
        expect_codes("R6", 12'h53C, 12'hFFF);
        read_check("R6", 8'hF9, 8'h23);

        // R7: sync rise loads both
        bus_write(8'hFD, 8'h1F);
        expect_codes("R7", 12'h123, 12'hF00);

        // R9: clear channel 0 and restore
        bus_write(8'hFD, 8'h17);
        expect_codes("R9", 12'h000, 12'hF00);
        bus_write(8'hFD, 8'h1F);
        expect_codes("R9", 12'h123, 12'hF00);

        // R8: 8-bit mode, no sync edge so no reload
        bus_write(8'hFD, 8'h9F);
        expect_codes("R8", 12'h123, 12'hF00);
        bus_write(8'hF9, 8'hAB);
        expect_codes("R8", 12'hAB0, 12'hF00);
        bus_write(8'hFA, 8'h07);
        expect_codes("R8", 12'hAB0, 12'hF00);

        // R7 collision: sync rise with mode change in one write
        bus_write(8'hFD, 8'h1B);
        bus_write(8'hFB, 8'h44);
        expect_codes("R7", 12'hAB0, 12'hF00);
        bus_write(8'hFD, 8'h9F);
        expect_codes("R7", 12'hAB0, 12'h440);

        // R7 R9 collision: sync rise with clear release
        bus_write(8'hFD, 8'h03);
        expect_codes("R9", 12'h000, 12'h000);
        bus_write(8'hFD, 8'h1F);
        expect_codes("R7", 12'h7AB, 12'hF44);

        // R3 R10: ranges and power-down of channel 1
        bus_write(8'hFD, 8'h7F);
        side_check("R3", 4'b1111);
        bus_write(8'hFD, 8'h7D);
        side_check("R10", 4'b1101);
        expect_codes("R10", 12'h7AB, 12'hF44);

        // R2: unmapped address
        bus_write(8'h80, 8'hFF);
        read_check("R2", 8'h80, 8'h00);
        read_check("R2", 8'hFD, 8'h7D);
        read_check("R2", 8'hFB, 8'h44);
        expect_codes("R2", 12'h7AB, 12'hF44);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule